// File: doc/BRIEF.md
# Replicating Load Alignment Decoder

This block classifies one encoding of a vector instruction that loads a single element from memory and copies it into every lane of one to four registers. It takes the element-size code, the register-count code, the alignment-hint bit and the base address. It reports four things: whether the encoding is illegal, the element size to use, the alignment in bytes that the encoding requires, and whether the address breaks that alignment.

The block is purely combinational, and all of its outputs follow the inputs in the same cycle. The instruction decode stage drives it. That stage raises an undefined-instruction exception when `undef_o` is high and an alignment exception when `fault_o` is high. The block does not fetch, access memory or deliver exceptions.

Top module: `repl_load_align_dec`

## Requirements
- R1: Size code 3 (`esize_i` = 2'b11) is legal only with four registers (`cnt_i` = 2'b11) and `hint_i` = 1. In that case `esize_o` = 2 (32-bit element) and `align_o` = 16.
- R2: Size code 3 with any other register count, or with `hint_i` = 0, sets `undef_o`.
- R3: When `hint_i` = 0 and the size code is 0, 1 or 2, the encoding is legal, `align_o` = 1 and `fault_o` stays low for every address.
- R4: With one register (`cnt_i` = 0), `hint_i` = 1 and byte elements (size code 0), `undef_o` is set.
- R5: With one register and `hint_i` = 1, size code 1 requires 2-byte alignment and size code 2 requires 4-byte alignment.
- R6: With two registers (`cnt_i` = 1) and `hint_i` = 1, `align_o` = 2^(size+1).
- R7: With three registers (`cnt_i` = 2) and `hint_i` = 1, `undef_o` is set for every size code.
- R8: With four registers and `hint_i` = 1, `align_o` = 2^(size+2), limited to 16. A 32-byte result becomes 16.
- R9: `fault_o` is high exactly when the encoding is legal and some address bit below log2(`align_o`) is 1. Higher address bits have no effect.
- R10: When `undef_o` is high, `fault_o` is low, `esize_o` = 0 and `align_o` = 1.
- R11: For a legal encoding with a size code of 0 to 2, `esize_o` equals the size code (0 byte, 1 halfword, 2 word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| esize_i | input | 2 | Element-size code, 0 byte to 3 special |
| cnt_i | input | 2 | Register count minus one |
| hint_i | input | 1 | Alignment-hint bit |
| addr_i | input | ADDR_W | Base address |
| undef_o | output | 1 | Encoding is undefined |
| esize_o | output | 2 | Effective element size code |
| align_o | output | CAP_LOG2+1 | Required alignment in bytes |
| fault_o | output | 1 | Address breaks required alignment |

## Verification
The undefined flag and the alignment fault can both be triggered by the same input vector. To provoke this, the bench applies illegal encodings with `hint_i` set, such as size code 3 with two registers or byte elements with one register, together with addresses whose low bits are nonzero. The result is correct only if `undef_o` is high, `fault_o` is low, and `align_o` has fallen back to 1. Legal encodings with the same addresses must still fault, which shows that the suppression depends on the encoding and not on the address.

// File: rtl/repl_load_align_dec.sv
module repl_load_align_dec #(
  parameter int ADDR_W   = 32,
  parameter int CAP_LOG2 = 4
) (
  input  logic [1:0]          esize_i,
  input  logic [1:0]          cnt_i,
  input  logic                hint_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                undef_o,
  output logic [1:0]          esize_o,
  output logic [CAP_LOG2:0]   align_o,
  output logic                fault_o
);

  localparam int RAW_MAX = 4;
  localparam int LW      = $clog2(RAW_MAX + 1);

  logic [LW-1:0]     lg;
  logic [LW-1:0]     lg_cap;
  logic [CAP_LOG2:0] mask;

  always_comb begin
    undef_o = 1'b0;
    esize_o = esize_i;
    lg      = '0;
    if (esize_i == 2'd3) begin
      if (cnt_i == 2'd3 && hint_i) begin
        esize_o = 2'd2;
        lg      = LW'(RAW_MAX);
      end else begin
        undef_o = 1'b1;
      end
    end else if (hint_i) begin
      case (cnt_i)
        2'd0: if (esize_i == 2'd0) undef_o = 1'b1;
              else lg = LW'(esize_i);
        2'd1: lg = LW'(esize_i) + LW'(1);
        2'd2: undef_o = 1'b1;
        default: lg = LW'(esize_i) + LW'(2);
      endcase
    end
    if (undef_o) begin
      esize_o = 2'd0;
      lg      = '0;
    end
  end

  assign lg_cap  = (lg > LW'(CAP_LOG2)) ? LW'(CAP_LOG2) : lg;
  assign align_o = {{CAP_LOG2{1'b0}}, 1'b1} << lg_cap;
  assign mask    = align_o - {{CAP_LOG2{1'b0}}, 1'b1};
  assign fault_o = !undef_o && |(addr_i[CAP_LOG2-1:0] & mask[CAP_LOG2-1:0]);

  always_comb begin
    // R10
    undef_masks_fault_chk: assert (!(undef_o && fault_o));
    // R3
    nohint_no_fault_chk: assert (hint_i || !fault_o);
    // R8
    align_cap_chk: assert ($onehot(align_o));
    // R1
    wide_remap_chk: assert (!(esize_i == 2'd3 && !undef_o) ||
                            (esize_o == 2'd2 && align_o == (CAP_LOG2+1)'(16)));
    // R7
    three_reg_hint_chk: assert (!(cnt_i == 2'd2 && hint_i) || undef_o);
  end

endmodule

// File: tb/tb_repl_load_align_dec.sv
module tb_repl_load_align_dec;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  esize_i, cnt_i, esize_o;
  logic        hint_i, undef_o, fault_o;
  logic [31:0] addr_i;
  logic [4:0]  align_o;
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  repl_load_align_dec dut (
    .esize_i(esize_i), .cnt_i(cnt_i), .hint_i(hint_i), .addr_i(addr_i),
    .undef_o(undef_o), .esize_o(esize_o), .align_o(align_o), .fault_o(fault_o)
  );

  task automatic apply(input string tag, input logic [1:0] es, input logic [1:0] cn,
                       input logic h, input logic [31:0] a, input logic xu,
                       input logic [1:0] xe, input logic [4:0] xa, input logic xf);
    @(posedge clk);
    esize_i = es; cnt_i = cn; hint_i = h; addr_i = a;
    @(negedge clk);
    n_vec++;
    if (undef_o !== xu || esize_o !== xe || align_o !== xa || fault_o !== xf) begin
      n_bad++;
      $display("FAIL %s: in es=%0d cnt=%0d h=%0d a=%h got u=%0d e=%0d al=%0d f=%0d exp u=%0d e=%0d al=%0d f=%0d",
               tag, es, cn, h, a, undef_o, esize_o, align_o, fault_o, xu, xe, xa, xf);
    end
  endtask

  task automatic t_idle();
    apply("R3 idle", 2'd0, 2'd0, 1'b0, 32'h0, 1'b0, 2'd0, 5'd1, 1'b0);
  endtask

  task automatic t_wide();
    apply("R1", 2'd3, 2'd3, 1'b1, 32'h100, 1'b0, 2'd2, 5'd16, 1'b0);
    apply("R1 R9", 2'd3, 2'd3, 1'b1, 32'h108, 1'b0, 2'd2, 5'd16, 1'b1);
  endtask

  task automatic t_wide_bad();
    for (int c = 0; c < 3; c++)
      apply("R2", 2'd3, 2'(c), 1'b1, 32'h0, 1'b1, 2'd0, 5'd1, 1'b0);
    apply("R2 nohint", 2'd3, 2'd3, 1'b0, 32'h0, 1'b1, 2'd0, 5'd1, 1'b0);
  endtask

  task automatic t_nohint();
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 4; c++)
        apply("R3 R11", 2'(s), 2'(c), 1'b0, 32'h7, 1'b0, 2'(s), 5'd1, 1'b0);
  endtask

  task automatic t_one();
    apply("R4", 2'd0, 2'd0, 1'b1, 32'h0, 1'b1, 2'd0, 5'd1, 1'b0);
    apply("R5", 2'd1, 2'd0, 1'b1, 32'h1, 1'b0, 2'd1, 5'd2, 1'b1);
    apply("R5", 2'd2, 2'd0, 1'b1, 32'h4, 1'b0, 2'd2, 5'd4, 1'b0);
    apply("R5 R9", 2'd2, 2'd0, 1'b1, 32'h6, 1'b0, 2'd2, 5'd4, 1'b1);
  endtask

  task automatic t_two();
    apply("R6", 2'd0, 2'd1, 1'b1, 32'h1, 1'b0, 2'd0, 5'd2, 1'b1);
    apply("R6", 2'd1, 2'd1, 1'b1, 32'h4, 1'b0, 2'd1, 5'd4, 1'b0);
    apply("R6 R9", 2'd2, 2'd1, 1'b1, 32'h4, 1'b0, 2'd2, 5'd8, 1'b1);
  endtask

  task automatic t_three();
    for (int s = 0; s < 3; s++)
      apply("R7", 2'(s), 2'd2, 1'b1, 32'h0, 1'b1, 2'd0, 5'd1, 1'b0);
  endtask

  task automatic t_four();
    apply("R8", 2'd0, 2'd3, 1'b1, 32'h2, 1'b0, 2'd0, 5'd4, 1'b1);
    apply("R8", 2'd1, 2'd3, 1'b1, 32'h8, 1'b0, 2'd1, 5'd8, 1'b0);
    apply("R8 cap", 2'd2, 2'd3, 1'b1, 32'h18, 1'b0, 2'd2, 5'd16, 1'b1);
    apply("R8 cap", 2'd2, 2'd3, 1'b1, 32'h20, 1'b0, 2'd2, 5'd16, 1'b0);
    apply("R9 high bits", 2'd2, 2'd3, 1'b1, 32'hFFFF_FFF0, 1'b0, 2'd2, 5'd16, 1'b0);
  endtask

  task automatic t_overlap();
    apply("R10", 2'd3, 2'd1, 1'b1, 32'h7, 1'b1, 2'd0, 5'd1, 1'b0);
    apply("R10", 2'd0, 2'd0, 1'b1, 32'h3, 1'b1, 2'd0, 5'd1, 1'b0);
    apply("R10", 2'd1, 2'd2, 1'b1, 32'hF, 1'b1, 2'd0, 5'd1, 1'b0);
  endtask

  initial begin
    esize_i = '0; cnt_i = '0; hint_i = 1'b0; addr_i = '0;
    t_idle();
    t_wide();
    t_wide_bad();
    t_nohint();
    t_one();
    t_two();
    t_three();
    t_four();
    t_overlap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule